// File: doc/BRIEF.md
# Conversion Start and Power-Down Sequencer

This block decides when a successive-approximation converter samples, converts and sleeps. It watches a hardware convert-start pin and a software convert request bit, and it reads the two-bit power-down code held in the control register. From these it drives the track/hold switch, issues a one-cycle start pulse to the converter core, raises a busy flag, and reports the power state as one of active, partial power-down or full power-down. The analog core is outside the block. All inputs are taken as synchronous to the system clock, and every interval is a count of clock cycles set by a parameter.

A conversion can be started in two ways. A falling edge on the pin starts it at once. A software request starts it after a fixed acquisition delay, so that a channel change written in the same register access still has time to settle. A conversion ends when an internal counter reaches the nominal conversion length, or, in the other build variant, when the core reports done. At that moment the power-down code and the pin level decide whether the block stays powered or goes to sleep. A one-cycle pulse is then sent back to clear the software request bit. Waking from a power-down costs a power-up interval, and during that interval the block accepts no start.

Top module: `conv_seq`

## Requirements
- R1: While `rst` is high and in the first cycle after it, the block is in full power-down: `pwr_full`=1, `pwr_active`=0, `pwr_partial`=0, and `hold`, `busy`, `core_start`, `sw_clear` are all 0.
- R2: In the powered idle state, a falling edge of `cvt_pin` sampled at a clock edge raises `hold` and `busy` from that edge. `core_start` is high for exactly that first cycle of the conversion.
- R3: In the powered idle state, a rising edge of `sw_start` raises `busy` at once and starts the conversion (`hold` and `core_start` high) exactly `ACQ_CYC` edges later.
- R4: With `EXT_DONE`=0, `hold` stays high for exactly `CONV_CYC` cycles. With `EXT_DONE`=1, it stays high until the edge at which `core_done` is sampled high, however long that takes.
- R5: `sw_clear` is high for exactly one cycle, starting at the edge on which `hold` falls.
- R6: With code 2'b01 or 2'b10 at the end of a conversion, a low `cvt_pin` sends the block to partial power-down (01) or full power-down (10). A high `cvt_pin` keeps it powered and idle.
- R7: Code 2'b00 forces full power-down at the first edge at which it is sampled outside a conversion. A running conversion completes and then ends in full power-down.
- R8: Code 2'b11 starts a power-up from either power-down state, and the block always stays powered at the end of a conversion.
- R9: From power-down with code 01 or 10, a rising edge of `cvt_pin` starts a power-up. Power-up keeps `busy` high and `pwr_active` high for `PWRUP_CYC` cycles, after which the block is idle.
- R10: Start requests (pin falling edge, software rising edge) are ignored during power-up, during the acquisition delay, during a conversion and in power-down. Under code 00, a pin rising edge in power-down is also ignored.
- R11: Exactly one of `pwr_active`, `pwr_partial`, `pwr_full` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cvt_pin | input | 1 | Hardware convert-start level (falling edge starts, rising edge wakes) |
| sw_start | input | 1 | Software convert request bit from the control register |
| pd_code | input | 2 | Power-down code: 00 full now, 01 partial at end, 10 full at end, 11 power up |
| core_done | input | 1 | End of conversion from the core (used when EXT_DONE=1) |
| hold | output | 1 | Track/hold control, 1 = hold |
| core_start | output | 1 | One-cycle start pulse to the converter core |
| busy | output | 1 | High during power-up, acquisition delay and conversion |
| pwr_active | output | 1 | Block is powered (including power-up) |
| pwr_partial | output | 1 | Partial power-down |
| pwr_full | output | 1 | Full power-down |
| sw_clear | output | 1 | One-cycle clear pulse for the software request bit |

## Verification
Every result is one register stage from the edge that samples its cause. A pin edge shows on `hold` and `core_start` in the cycle right after that edge. A software request shows on `busy` after one edge and on `hold` after `ACQ_CYC` edges. The end of a conversion, the power decision and `sw_clear` all appear after the edge that counts the last conversion cycle. The bench drives inputs one time unit after a rising edge and compares all outputs one time unit after the next rising edge, so each table row holds exactly the outputs that its own inputs should produce.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_WAKE = 3'd1,
        ST_IDLE = 3'd2,
        ST_ACQ  = 3'd3,
        ST_CONV = 3'd4
    } seq_state_e;

    typedef enum logic [1:0] {
        PD_FULL_NOW = 2'b00,
        PD_PART_EOC = 2'b01,
        PD_FULL_EOC = 2'b10,
        PD_POWER_UP = 2'b11
    } pd_code_e;

    typedef enum logic [1:0] {
        EOC_STAY = 2'd0,
        EOC_PART = 2'd1,
        EOC_FULL = 2'd2
    } eoc_act_e;

    typedef struct packed {
        logic active;
        logic partial;
        logic full;
    } pwr_t;

    // Decision taken on the edge that ends a conversion.
    function automatic eoc_act_e eoc_decide(input logic [1:0] code, input logic pin_level);
        eoc_act_e act;
        case (code)
            PD_FULL_NOW: act = EOC_FULL;
            PD_PART_EOC: act = pin_level ? EOC_STAY : EOC_PART;
            PD_FULL_EOC: act = pin_level ? EOC_STAY : EOC_FULL;
            default:     act = EOC_STAY;
        endcase
        return act;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_edge.sv
module seq_edge #(
    parameter logic RST_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic rise,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_LEVEL;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;
    assign fall = ~lvl & prev_q;
endmodule

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int W         = 8,
    parameter int ACQ_CYC   = 4,
    parameter int PWRUP_CYC = 8,
    parameter int CONV_CYC  = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pin_lvl,
    input  logic         pin_rise,
    input  logic         pin_fall,
    input  logic         sw_rise,
    input  logic [1:0]   pd_code,
    input  logic         tmr_zero,
    input  logic         conv_end,
    output logic         tmr_load,
    output logic [W-1:0] tmr_val,
    output logic         hold,
    output logic         busy,
    output logic         core_start,
    output pwr_t         pwr,
    output logic         sw_clear
);
    localparam logic [W-1:0] ACQ_LOAD   = W'(ACQ_CYC - 1);
    localparam logic [W-1:0] PWRUP_LOAD = W'(PWRUP_CYC - 1);
    localparam logic [W-1:0] CONV_LOAD  = W'(CONV_CYC - 1);

    seq_state_e st_q, st_d;
    logic       full_q, full_d;
    logic       start_q, clr_q;
    logic       code_off, code_up;

    assign code_off = (pd_code == PD_FULL_NOW);
    assign code_up  = (pd_code == PD_POWER_UP);

    always_comb begin
        st_d     = st_q;
        full_d   = full_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_OFF: begin
                if (code_off) begin
                    full_d = 1'b1;
                end else if (code_up || pin_rise) begin
                    st_d     = ST_WAKE;
                    tmr_load = 1'b1;
                    tmr_val  = PWRUP_LOAD;
                end
            end
            ST_WAKE: begin
                if (code_off) begin
                    st_d   = ST_OFF;
                    full_d = 1'b1;
                end else if (tmr_zero) begin
                    st_d = ST_IDLE;
                end
            end
            ST_IDLE: begin
                if (code_off) begin
                    st_d   = ST_OFF;
                    full_d = 1'b1;
                end else if (pin_fall) begin
                    st_d     = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = CONV_LOAD;
                end else if (sw_rise) begin
                    st_d     = ST_ACQ;
                    tmr_load = 1'b1;
                    tmr_val  = ACQ_LOAD;
                end
            end
            ST_ACQ: begin
                if (code_off) begin
                    st_d   = ST_OFF;
                    full_d = 1'b1;
                end else if (tmr_zero) begin
                    st_d     = ST_CONV;
                    tmr_load = 1'b1;
                    tmr_val  = CONV_LOAD;
                end
            end
            ST_CONV: begin
                if (conv_end) begin
                    case (eoc_decide(pd_code, pin_lvl))
                        EOC_PART: begin
                            st_d   = ST_OFF;
                            full_d = 1'b0;
                        end
                        EOC_FULL: begin
                            st_d   = ST_OFF;
                            full_d = 1'b1;
                        end
                        default:  st_d = ST_IDLE;
                    endcase
                end
            end
            default: begin
                st_d   = ST_OFF;
                full_d = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_OFF;
            full_q  <= 1'b1;
            start_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            full_q  <= full_d;
            start_q <= (st_d == ST_CONV) && (st_q != ST_CONV);
            clr_q   <= (st_q == ST_CONV) && (st_d != ST_CONV);
        end
    end

    assign hold        = (st_q == ST_CONV);
    assign busy        = (st_q == ST_WAKE) || (st_q == ST_ACQ) || (st_q == ST_CONV);
    assign core_start  = start_q;
    assign sw_clear    = clr_q;
    assign pwr.active  = (st_q != ST_OFF);
    assign pwr.partial = (st_q == ST_OFF) && !full_q;
    assign pwr.full    = (st_q == ST_OFF) && full_q;
endmodule

// File: rtl/conv_seq.sv
module conv_seq
    import conv_seq_pkg::*;
#(
    parameter int ACQ_CYC   = 40,
    parameter int PWRUP_CYC = 150,
    parameter int CONV_CYC  = 230,
    parameter bit EXT_DONE  = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cvt_pin,
    input  logic       sw_start,
    input  logic [1:0] pd_code,
    input  logic       core_done,
    output logic       hold,
    output logic       core_start,
    output logic       busy,
    output logic       pwr_active,
    output logic       pwr_partial,
    output logic       pwr_full,
    output logic       sw_clear
);
    localparam int MAX_CYC = max3(ACQ_CYC, PWRUP_CYC, CONV_CYC);
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    logic             pin_rise, pin_fall, sw_rise, sw_fall_unused;
    logic             tmr_load, tmr_zero, conv_end;
    logic [CNT_W-1:0] tmr_val;
    pwr_t             pwr;

    seq_edge #(.RST_LEVEL(1'b1)) u_pin_edge (
        .clk(clk), .rst(rst), .lvl(cvt_pin), .rise(pin_rise), .fall(pin_fall)
    );

    seq_edge #(.RST_LEVEL(1'b1)) u_sw_edge (
        .clk(clk), .rst(rst), .lvl(sw_start), .rise(sw_rise), .fall(sw_fall_unused)
    );

    seq_timer #(.W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
    );

    generate
        if (EXT_DONE) begin : g_ext_done
            assign conv_end = core_done;
        end else begin : g_cnt_done
            logic done_unused;
            assign done_unused = core_done;
            assign conv_end    = tmr_zero;
        end
    endgenerate

    seq_ctrl #(
        .W(CNT_W), .ACQ_CYC(ACQ_CYC), .PWRUP_CYC(PWRUP_CYC), .CONV_CYC(CONV_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .pin_lvl(cvt_pin), .pin_rise(pin_rise), .pin_fall(pin_fall),
        .sw_rise(sw_rise), .pd_code(pd_code),
        .tmr_zero(tmr_zero), .conv_end(conv_end),
        .tmr_load(tmr_load), .tmr_val(tmr_val),
        .hold(hold), .busy(busy), .core_start(core_start),
        .pwr(pwr), .sw_clear(sw_clear)
    );

    assign pwr_active  = pwr.active;
    assign pwr_partial = pwr.partial;
    assign pwr_full    = pwr.full;
endmodule

// File: rtl/conv_seq_chk.sv
module conv_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] pd_code,
    input logic       hold,
    input logic       busy,
    input logic       core_start,
    input logic       sw_clear,
    input logic       pwr_active,
    input logic       pwr_partial,
    input logic       pwr_full
);
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        core_start |=> !core_start);                                            // R2
    AST_START_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        core_start |-> (hold && busy));                                         // R2
    AST_CLEAR_AFTER_END: assert property (@(posedge clk) disable iff (rst)
        sw_clear |-> (!hold && $past(hold)));                                   // R5
    AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        sw_clear |=> !sw_clear);                                                // R5
    AST_CODE00_SLEEPS: assert property (@(posedge clk) disable iff (rst)
        (pd_code == 2'b00 && !hold) |=> pwr_full);                              // R7
    AST_CODE11_STAYS: assert property (@(posedge clk) disable iff (rst)
        ($fell(hold) && $past(pd_code) == 2'b11) |-> pwr_active);               // R8
    AST_CODE11_WAKES: assert property (@(posedge clk) disable iff (rst)
        ((pwr_full || pwr_partial) && pd_code == 2'b11) |=> (busy && pwr_active)); // R8
    AST_QUIET_ASLEEP: assert property (@(posedge clk) disable iff (rst)
        (pwr_full || pwr_partial) |-> (!busy && !hold));                        // R10
    AST_PWR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $countones({pwr_active, pwr_partial, pwr_full}) == 1);                  // R11
endmodule

bind conv_seq conv_seq_chk u_chk (
    .clk(clk), .rst(rst), .pd_code(pd_code), .hold(hold), .busy(busy),
    .core_start(core_start), .sw_clear(sw_clear), .pwr_active(pwr_active),
    .pwr_partial(pwr_partial), .pwr_full(pwr_full)
);

// File: tb/conv_seq_bench.sv
module conv_seq_bench;
    localparam int ACQ   = 3;
    localparam int PWRUP = 5;
    localparam int CONV  = 6;
    localparam logic [2:0] ACT = 3'b100;
    localparam logic [2:0] PRT = 3'b010;
    localparam logic [2:0] FUL = 3'b001;

    typedef struct packed {
        logic       p;
        logic       s;
        logic [1:0] c;
        logic [6:0] exp;   // {hold, busy, core_start, active, partial, full, sw_clear}
        logic [3:0] req;
    } vec_t;

    function automatic vec_t mk(input logic p, input logic s, input logic [1:0] c,
                                input logic h, input logic b, input logic st,
                                input logic [2:0] pw, input logic cl, input int r);
        vec_t v;
        v.p = p; v.s = s; v.c = c;
        v.exp = {h, b, st, pw, cl};
        v.req = 4'(r);
        return v;
    endfunction

    localparam int NV = 60;
    localparam vec_t VEC [NV] = '{
        mk(1,0,2'b00, 0,0,0,FUL,0, 7),   // 0  R7 stay asleep
        mk(1,0,2'b11, 0,1,0,ACT,0, 8),   // 1  R8 code 11 wakes
        mk(1,0,2'b11, 0,1,0,ACT,0, 9),   // 2  R9 power-up
        mk(0,0,2'b11, 0,1,0,ACT,0,10),   // 3  R10 fall during power-up
        mk(1,0,2'b11, 0,1,0,ACT,0,10),   // 4
        mk(1,0,2'b11, 0,1,0,ACT,0, 9),   // 5
        mk(1,0,2'b11, 0,0,0,ACT,0, 9),   // 6  idle after PWRUP
        mk(0,0,2'b11, 1,1,1,ACT,0, 2),   // 7  R2 pin start
        mk(0,0,2'b11, 1,1,0,ACT,0, 2),   // 8
        mk(0,1,2'b11, 1,1,0,ACT,0,10),   // 9  R10 software during conversion
        mk(0,1,2'b11, 1,1,0,ACT,0,10),   // 10
        mk(0,0,2'b11, 1,1,0,ACT,0, 4),   // 11 R4
        mk(0,0,2'b11, 1,1,0,ACT,0, 4),   // 12
        mk(0,0,2'b11, 0,0,0,ACT,1, 8),   // 13 R8 end, stays powered, R5 clear
        mk(0,0,2'b11, 0,0,0,ACT,0, 5),   // 14
        mk(0,1,2'b10, 0,1,0,ACT,0, 3),   // 15 R3 software request
        mk(0,1,2'b10, 0,1,0,ACT,0, 3),   // 16
        mk(0,1,2'b10, 0,1,0,ACT,0, 3),   // 17
        mk(0,1,2'b10, 1,1,1,ACT,0, 3),   // 18 start ACQ edges later
        mk(0,1,2'b10, 1,1,0,ACT,0, 4),   // 19
        mk(0,1,2'b10, 1,1,0,ACT,0, 4),   // 20
        mk(0,1,2'b10, 1,1,0,ACT,0, 4),   // 21
        mk(0,1,2'b10, 1,1,0,ACT,0, 4),   // 22
        mk(0,1,2'b10, 1,1,0,ACT,0, 4),   // 23
        mk(0,0,2'b10, 0,0,0,FUL,1, 6),   // 24 R6 code 10, pin low -> full
        mk(0,0,2'b10, 0,0,0,FUL,0, 5),   // 25
        mk(1,0,2'b10, 0,1,0,ACT,0, 9),   // 26 R9 pin rise wakes
        mk(1,1,2'b10, 0,1,0,ACT,0,10),   // 27 software during power-up
        mk(1,0,2'b10, 0,1,0,ACT,0, 9),   // 28
        mk(1,0,2'b10, 0,1,0,ACT,0, 9),   // 29
        mk(1,0,2'b10, 0,1,0,ACT,0, 9),   // 30
        mk(1,0,2'b10, 0,0,0,ACT,0, 9),   // 31
        mk(1,1,2'b01, 0,1,0,ACT,0, 3),   // 32
        mk(1,1,2'b01, 0,1,0,ACT,0, 3),   // 33
        mk(1,1,2'b01, 0,1,0,ACT,0, 3),   // 34
        mk(1,1,2'b01, 1,1,1,ACT,0, 3),   // 35
        mk(1,1,2'b01, 1,1,0,ACT,0, 4),   // 36
        mk(1,1,2'b01, 1,1,0,ACT,0, 4),   // 37
        mk(1,1,2'b01, 1,1,0,ACT,0, 4),   // 38
        mk(1,1,2'b01, 1,1,0,ACT,0, 4),   // 39
        mk(1,1,2'b01, 1,1,0,ACT,0, 4),   // 40
        mk(1,0,2'b01, 0,0,0,ACT,1, 6),   // 41 R6 pin high keeps power
        mk(0,0,2'b01, 1,1,1,ACT,0, 2),   // 42
        mk(0,0,2'b01, 1,1,0,ACT,0, 4),   // 43
        mk(0,0,2'b01, 1,1,0,ACT,0, 4),   // 44
        mk(0,0,2'b01, 1,1,0,ACT,0, 4),   // 45
        mk(0,0,2'b01, 1,1,0,ACT,0, 4),   // 46
        mk(0,0,2'b01, 1,1,0,ACT,0, 4),   // 47
        mk(0,0,2'b01, 0,0,0,PRT,1, 6),   // 48 code 01, pin low -> partial
        mk(0,0,2'b01, 0,0,0,PRT,0,11),   // 49 R11 partial alone
        mk(0,0,2'b00, 0,0,0,FUL,0, 7),   // 50 partial -> full on 00
        mk(0,0,2'b00, 0,0,0,FUL,0,11),   // 51
        mk(0,0,2'b11, 0,1,0,ACT,0, 8),   // 52
        mk(0,0,2'b11, 0,1,0,ACT,0, 9),   // 53
        mk(0,0,2'b11, 0,1,0,ACT,0, 9),   // 54
        mk(0,0,2'b11, 0,1,0,ACT,0, 9),   // 55
        mk(0,0,2'b11, 0,1,0,ACT,0, 9),   // 56
        mk(0,0,2'b11, 0,0,0,ACT,0, 9),   // 57
        mk(0,0,2'b00, 0,0,0,FUL,0, 7),   // 58 idle -> full at once
        mk(1,0,2'b00, 0,0,0,FUL,0,10)    // 59 rise ignored under 00
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cvt_pin = 1'b1, sw_start = 1'b0, core_done = 1'b0;
    logic [1:0] pd_code = 2'b00;
    logic hold, core_start, busy, pwr_active, pwr_partial, pwr_full, sw_clear;

    logic e_pin = 1'b1, e_sw = 1'b0, e_done = 1'b0;
    logic [1:0] e_code = 2'b00;
    logic e_hold, e_start, e_busy, e_act, e_part, e_full, e_clr;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    conv_seq #(.ACQ_CYC(ACQ), .PWRUP_CYC(PWRUP), .CONV_CYC(CONV), .EXT_DONE(1'b0)) u_conv_seq (
        .clk(clk), .rst(rst), .cvt_pin(cvt_pin), .sw_start(sw_start), .pd_code(pd_code),
        .core_done(core_done), .hold(hold), .core_start(core_start), .busy(busy),
        .pwr_active(pwr_active), .pwr_partial(pwr_partial), .pwr_full(pwr_full),
        .sw_clear(sw_clear)
    );

    conv_seq #(.ACQ_CYC(ACQ), .PWRUP_CYC(PWRUP), .CONV_CYC(CONV), .EXT_DONE(1'b1)) u_conv_seq_ext (
        .clk(clk), .rst(rst), .cvt_pin(e_pin), .sw_start(e_sw), .pd_code(e_code),
        .core_done(e_done), .hold(e_hold), .core_start(e_start), .busy(e_busy),
        .pwr_active(e_act), .pwr_partial(e_part), .pwr_full(e_full), .sw_clear(e_clr)
    );

    function automatic logic [6:0] outs();
        return {hold, busy, core_start, pwr_active, pwr_partial, pwr_full, sw_clear};
    endfunction

    function automatic logic [6:0] e_outs();
        return {e_hold, e_busy, e_start, e_act, e_part, e_full, e_clr};
    endfunction

    task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%b exp=%b (hold,busy,start,act,part,full,clr) t=%0t",
                     req, act, exp, $time);
        end
    endtask

    task automatic step(input logic p, input logic s, input logic [1:0] c);
        cvt_pin = p; sw_start = s; pd_code = c;
        @(posedge clk); #1;
    endtask

    task automatic estep(input logic p, input logic [1:0] c, input logic d);
        e_pin = p; e_code = c; e_done = d;
        @(posedge clk); #1;
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000) begin
                bad++;
                total++;
                $display("FAIL watchdog act=%0d exp<=5000 cycles", cyc);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 in reset", outs(), 7'b000_001_0);
        check("R1 ext in reset", e_outs(), 7'b000_001_0);
        rst = 1'b0;
        @(posedge clk); #1;
        check("R1 first cycle after reset", outs(), 7'b000_001_0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].p, VEC[i].s, VEC[i].c);
            check($sformatf("R%0d row %0d", VEC[i].req, i), outs(), VEC[i].exp);
        end

        // R7: code 00 arriving mid-conversion lets it finish, then full power-down
        step(1, 0, 2'b11);
        repeat (PWRUP) step(1, 0, 2'b11);
        check("R9 idle after power-up", outs(), 7'b000_100_0);
        step(0, 0, 2'b11);
        check("R2 start", outs(), 7'b111_100_0);
        step(0, 0, 2'b00);
        step(0, 0, 2'b00);
        check("R7 conversion not cut", outs(), 7'b110_100_0);
        repeat (CONV - 3) step(0, 0, 2'b00);
        check("R7 still converting", outs(), 7'b110_100_0);
        step(0, 0, 2'b00);
        check("R7 full after end", outs(), 7'b000_001_1);

        // R4: done input variant, conversion outlasts CONV until done
        repeat (PWRUP + 1) estep(1, 2'b11, 0);
        check("R9 ext idle", e_outs(), 7'b000_100_0);
        estep(0, 2'b11, 0);
        check("R2 ext start", e_outs(), 7'b111_100_0);
        repeat (CONV + 3) estep(0, 2'b11, 0);
        check("R4 ext still holding past CONV", e_outs(), 7'b110_100_0);
        estep(0, 2'b11, 1);
        check("R4 ext ends on done", e_outs(), 7'b000_100_1);
        estep(0, 2'b11, 0);
        check("R5 ext clear one cycle", e_outs(), 7'b000_100_0);

        // R1: reset during power-up returns to full power-down
        step(1, 0, 2'b11);
        check("R8 wake before reset", outs(), 7'b010_100_0);
        rst = 1'b1;
        step(1, 0, 2'b11);
        check("R1 reset mid power-up", outs(), 7'b000_001_0);
        rst = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end
endmodule